// File: doc/BRIEF.md
# Dual-Button Long-Press Reset Controller

This block turns two active-low push-button inputs into two active-low outputs. The first output, `and_out_no`, is a filtered AND of the buttons. It pulls low once both buttons have been seen pressed together for a debounce interval. It releases once the joint press has been seen broken for the same interval. The second output, `rst_out_no`, gives one fixed-width reset pulse. The pulse is issued only after the joint press has lasted a long setup period without a break. Both outputs model open-drain pins: 0 means the pin is pulled down, 1 means it is released. Neither output ever drives a high level. Tying the two button inputs together gives a single-button long-press reset.

The raw buttons are asynchronous, so each passes through a two-flop synchronizer. A prescaler divides the clock down to a tick at `TICK_HZ` (1 kHz by default). The debounce interval, the setup period and the pulse width are all counted in ticks. The setup-period and pulse-width selects are static configuration pins. The controller latches them only while it is idle. A four-state controller (idle, setup, pulse, wait-for-release) makes sure each press gives exactly one pulse.

Top module: `dual_button_reset`

## Requirements
- R1: Both buttons must stay pressed, as seen through the debounce filter, for S ticks in a row. `rst_out_no` then pulls low for exactly P ticks. Measured from the fall of `and_out_no` to the fall of `rst_out_no`, the delay lies between (S-1)*C+1 and S*C+2 clock cycles, where C = CLK_HZ/TICK_HZ. A reset pulse only ever begins while `and_out_no` is low.
- R2: `setup_sel_i` = k gives S = (6+2k)*TICK_HZ ticks, so 6, 8, 10 or 12 s. `pulse_sel_i` gives P: 0 means TICK_HZ/2 ticks, 1 means TICK_HZ ticks, and 2 or 3 mean 2*TICK_HZ ticks. Both selects are sampled only in the idle state. A change made during a press has no effect on that press.
- R3: The setup timer clears if the debounced joint press breaks during the setup period. The full S ticks must then elapse again from the next debounced joint press.
- R4: Keeping both buttons pressed after the pulse has been issued produces no further pulse.
- R5: Releasing either or both buttons while the pulse is active neither shortens the pulse nor restarts the setup timer.
- R6: After the pulse, the controller re-arms only once both buttons have been seen released for DB_TICKS consecutive ticks. A shorter release does not re-arm it.
- R7: `and_out_no` pulls low once the both-pressed condition has been seen at DB_TICKS consecutive ticks. It releases once the condition has been seen absent at DB_TICKS consecutive ticks. A change lasting less than DB_TICKS-1 tick periods leaves it unchanged. The response latency from a button edge is between (DB_TICKS-1)*C+2 and DB_TICKS*C+3 cycles.
- R8: Both outputs behave the same whichever button is pressed first, and also when the two buttons are driven together.
- R9: While `por_ni` is low, and after it rises with the buttons released, both outputs are released (1) and the controller is idle and armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock at CLK_HZ |
| por_ni | input | 1 | Asynchronous active-low power-on reset |
| btn_a_ni | input | 1 | First button, active low, asynchronous |
| btn_b_ni | input | 1 | Second button, active low, asynchronous |
| setup_sel_i | input | 2 | Setup period select, static |
| pulse_sel_i | input | 2 | Reset pulse width select, static |
| and_out_no | output | 1 | Debounced both-pressed indication, 0 = pulled low |
| rst_out_no | output | 1 | Reset pulse, 0 = pulled low |

## Verification
The assertions assume that the buttons are level signals which may bounce but are free of metastability after the synchronizer. They also assume that the selects are not sampled outside the idle state, so a select edge may fall anywhere. The stimulus changes every input half a cycle away from the active edge. Select changes are made either while idle or deliberately in mid-press to exercise R2. The bounces injected are either clearly shorter than DB_TICKS-1 tick periods or clearly longer than DB_TICKS periods plus the synchronizer delay, so every expected filter outcome is decided.

// File: rtl/mrst_pkg.sv
`timescale 1ns/1ps
package mrst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_PULSE = 2'd2,
    ST_WAIT  = 2'd3
  } mrst_state_e;

  // Setup period in seconds for a select value.
  function automatic int setup_seconds(input logic [1:0] sel);
    return 6 + 2 * int'(sel);
  endfunction

  // Pulse width in ticks for a select value and tick rate.
  function automatic int pulse_ticks(input logic [1:0] sel, input int tps);
    case (sel)
      2'd0:    return tps / 2;
      2'd1:    return tps;
      default: return 2 * tps;
    endcase
  endfunction

endpackage

// File: rtl/mrst_sync.sv
`timescale 1ns/1ps
module mrst_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[0] <= '1;
          else         stg_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[s] <= '1;
          else         stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/mrst_tick.sv
`timescale 1ns/1ps
module mrst_tick #(
  parameter int CLKS_PER_TICK = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  generate
    if (CLKS_PER_TICK <= 1) begin : g_every
      logic unused_w;
      assign unused_w = clk_i ^ rst_ni;
      assign tick_o   = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(CLKS_PER_TICK);
      logic [CW-1:0] cnt_q;
      logic          tick_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q  <= '0;
          tick_q <= 1'b0;
        end else if (cnt_q == CW'(CLKS_PER_TICK - 1)) begin
          cnt_q  <= '0;
          tick_q <= 1'b1;
        end else begin
          cnt_q  <= cnt_q + CW'(1);
          tick_q <= 1'b0;
        end
      end

      assign tick_o = tick_q;

      AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_q |=> !tick_q); // R1
    end
  endgenerate

endmodule

// File: rtl/mrst_debounce.sv
`timescale 1ns/1ps
module mrst_debounce #(
  parameter int   TICKS = 2,
  parameter logic INIT  = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic level_i,
  output logic state_o
);

  localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= INIT;
      cnt_q <= '0;
    end else if (level_i == st_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == CW'(TICKS - 1)) begin
        st_q  <= level_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign state_o = st_q;

  AST_DB_HOLD_WHEN_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == st_q) |=> $stable(st_q)); // R7
  AST_DB_MOVES_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(st_q)); // R7
  AST_DB_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(TICKS)); // R7

endmodule

// File: rtl/mrst_ctrl.sv
`timescale 1ns/1ps
module mrst_ctrl
  import mrst_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       both_low_i,
  input  logic       both_high_i,
  input  logic [1:0] setup_sel_i,
  input  logic [1:0] pulse_sel_i,
  output logic       pulse_o
);

  localparam int CW = $clog2(12 * TICKS_PER_SEC + 1);

  mrst_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] setup_lim_q, pulse_lim_q;
  logic [CW-1:0] setup_lim_d, pulse_lim_d;

  assign setup_lim_d = CW'(setup_seconds(setup_sel_i) * TICKS_PER_SEC - 1);
  assign pulse_lim_d = CW'(pulse_ticks(pulse_sel_i, TICKS_PER_SEC) - 1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (both_low_i) state_d = ST_SETUP;
      end
      ST_SETUP: begin
        if (!both_low_i) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (tick_i) begin
          if (cnt_q == setup_lim_q) begin
            state_d = ST_PULSE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
      ST_PULSE: begin
        if (tick_i) begin
          if (cnt_q == pulse_lim_q) begin
            state_d = ST_WAIT;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
      default: begin
        if (both_high_i) state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      setup_lim_q <= CW'(6 * TICKS_PER_SEC - 1);
      pulse_lim_q <= CW'(TICKS_PER_SEC / 2 - 1);
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (state_q == ST_IDLE) begin
        setup_lim_q <= setup_lim_d;
        pulse_lim_q <= pulse_lim_d;
      end
    end
  end

  assign pulse_o = (state_q == ST_PULSE);

  AST_PULSE_ONLY_AFTER_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_SETUP && state_q != ST_PULSE) |=> state_q != ST_PULSE); // R1
  AST_SETUP_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETUP) |-> cnt_q <= setup_lim_q); // R1
  AST_LIMITS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> ($stable(setup_lim_q) && $stable(pulse_lim_q))); // R2
  AST_SETUP_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETUP && !both_low_i) |=> state_q == ST_IDLE); // R3
  AST_PULSE_NO_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PULSE) |=> (state_q == ST_PULSE || state_q == ST_WAIT)); // R4
  AST_PULSE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PULSE && !tick_i) |=> state_q == ST_PULSE); // R5
  AST_WAIT_FOR_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !both_high_i) |=> state_q == ST_WAIT); // R6

endmodule

// File: rtl/dual_button_reset.sv
`timescale 1ns/1ps
module dual_button_reset #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int TICK_HZ     = 1000,
  parameter int DB_TICKS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       por_ni,
  input  logic       btn_a_ni,
  input  logic       btn_b_ni,
  input  logic [1:0] setup_sel_i,
  input  logic [1:0] pulse_sel_i,
  output logic       and_out_no,
  output logic       rst_out_no
);

  localparam int CLKS_PER_TICK = CLK_HZ / TICK_HZ;

  logic [1:0] btn_raw, btn_s;
  logic       tick, low_raw, high_raw, low_db, high_db, pulse;

  assign btn_raw = {btn_b_ni, btn_a_ni};

  mrst_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(por_ni), .d_i(btn_raw), .q_o(btn_s)
  );

  mrst_tick #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
    .clk_i(clk_i), .rst_ni(por_ni), .tick_o(tick)
  );

  assign low_raw  = ~btn_s[0] & ~btn_s[1];
  assign high_raw =  btn_s[0] &  btn_s[1];

  mrst_debounce #(.TICKS(DB_TICKS), .INIT(1'b0)) u_db_low (
    .clk_i(clk_i), .rst_ni(por_ni), .tick_i(tick),
    .level_i(low_raw), .state_o(low_db)
  );

  mrst_debounce #(.TICKS(DB_TICKS), .INIT(1'b1)) u_db_high (
    .clk_i(clk_i), .rst_ni(por_ni), .tick_i(tick),
    .level_i(high_raw), .state_o(high_db)
  );

  mrst_ctrl #(.TICKS_PER_SEC(TICK_HZ)) u_ctrl (
    .clk_i(clk_i), .rst_ni(por_ni), .tick_i(tick),
    .both_low_i(low_db), .both_high_i(high_db),
    .setup_sel_i(setup_sel_i), .pulse_sel_i(pulse_sel_i),
    .pulse_o(pulse)
  );

  assign and_out_no = ~low_db;
  assign rst_out_no = ~pulse;

  AST_PULSE_NEEDS_AND: assert property (@(posedge clk_i) disable iff (!por_ni)
    $fell(rst_out_no) |-> $past(!and_out_no)); // R1
  AST_FILTERS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!por_ni)
    !(low_db && high_db)); // R7

endmodule

// File: tb/dual_button_reset_test.sv
`timescale 1ns/1ps
module dual_button_reset_test;
  localparam int CPT = 4;
  localparam int TPS = 4;
  localparam int DB  = 3;

  logic clk = 1'b0, por_n = 1'b0, ba = 1'b1, bb = 1'b1;
  logic [1:0] ss = 2'd0, ps = 2'd0;
  logic and_n, rst_n;

  always #2.5 clk = ~clk;

  dual_button_reset #(.CLK_HZ(CPT*TPS), .TICK_HZ(TPS), .DB_TICKS(DB)) uut (
    .clk_i(clk), .por_ni(por_n), .btn_a_ni(ba), .btn_b_ni(bb),
    .setup_sel_i(ss), .pulse_sel_i(ps),
    .and_out_no(and_n), .rst_out_no(rst_n)
  );

  int cyc = 0, t_af = 0, t_ar = 0, t_rf = 0, t_rr = 0, n_rf = 0, n_ar = 0;
  logic p_and = 1'b1, p_rst = 1'b1;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (p_and && !and_n) t_af = cyc;
    if (!p_and && and_n) begin t_ar = cyc; n_ar = n_ar + 1; end
    if (p_rst && !rst_n) begin t_rf = cyc; n_rf = n_rf + 1; end
    if (!p_rst && rst_n) t_rr = cyc;
    p_and = and_n;
    p_rst = rst_n;
  end

  function automatic int s_cyc(input int k);
    return (6 + 2 * k) * TPS * CPT;
  endfunction

  function automatic int p_cyc(input int k);
    return ((k == 0) ? TPS / 2 : (k == 1) ? TPS : 2 * TPS) * CPT;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chkw(input string req, input int act, input int lo, input int hi);
    tests++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // order 0: a first, 1: b first, 2: both together (tied buttons)
  task automatic press(input int ord, output int td);
    if (ord == 0)      begin ba = 1'b0; waitc(3); bb = 1'b0; end
    else if (ord == 1) begin bb = 1'b0; waitc(3); ba = 1'b0; end
    else               begin ba = 1'b0; bb = 1'b0; end
    td = cyc;
  endtask

  task automatic release_settle();
    ba = 1'b1; bb = 1'b1;
    waitc(2 * DB * CPT + 20);
  endtask

  task automatic run(input int s, input int p, input int ord);
    int td, tr, n0, S, P;
    S = s_cyc(s); P = p_cyc(p);
    ss = 2'(s); ps = 2'(p);
    waitc(3);
    n0 = n_rf;
    press(ord, td);
    waitc(DB * CPT + 6);
    chkw($sformatf("R8 R7 and fall latency ord %0d", ord), t_af - td, (DB-1)*CPT + 2, DB*CPT + 3);
    waitc(S + 4);
    chk(n_rf == n0 + 1, "R1 one pulse issued", n_rf - n0, 1);
    chkw($sformatf("R2 setup delay sel %0d", s), t_rf - t_af, S - CPT + 1, S + 2);
    waitc(P + S + 10);
    chk(t_rr - t_rf == P, $sformatf("R2 pulse width sel %0d", p), t_rr - t_rf, P);
    chk(n_rf == n0 + 1, "R4 no second pulse while held", n_rf - n0, 1);
    ba = 1'b1; bb = 1'b1;
    tr = cyc;
    waitc(DB * CPT + 8);
    chkw("R7 and release latency", t_ar - tr, (DB-1)*CPT + 2, DB*CPT + 3);
    waitc(DB * CPT + 10);
  endtask

  initial begin
    int td, n0, na, t1;
    waitc(5);
    chk(and_n == 1'b1, "R9 and released in reset", int'(and_n), 1);
    chk(rst_n == 1'b1, "R9 reset released in reset", int'(rst_n), 1);
    por_n = 1'b1;
    waitc(30);
    chk(and_n == 1'b1 && rst_n == 1'b1, "R9 outputs released after reset",
        int'({and_n, rst_n}), 3);

    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 4; p++)
        run(s, p, (s + p) % 3);

    // R3: a debounced break in setup restarts the timer
    ss = 2'd0; ps = 2'd0; waitc(3);
    n0 = n_rf;
    press(2, td);
    waitc(DB * CPT + 6 + 40);
    bb = 1'b1;
    waitc(DB * CPT + 8);
    chk(and_n == 1'b1, "R3 break seen by filter", int'(and_n), 1);
    bb = 1'b0;
    waitc(DB * CPT + 6);
    t1 = t_af;
    waitc(s_cyc(0) + 4);
    chk(n_rf == n0 + 1, "R3 single pulse after restart", n_rf - n0, 1);
    chkw("R3 delay from second press", t_rf - t1, s_cyc(0) - CPT + 1, s_cyc(0) + 2);
    waitc(p_cyc(0) + 4);
    release_settle();

    // R7: short bounce during setup is ignored and the timer keeps running
    n0 = n_rf; na = n_ar;
    press(0, td);
    waitc(DB * CPT + 6);
    t1 = t_af;
    waitc(30);
    ba = 1'b1; waitc(5); ba = 1'b0;
    waitc(s_cyc(0));
    chk(n_ar == na, "R7 short bounce ignored", n_ar - na, 0);
    chk(n_rf == n0 + 1, "R3 bounce does not clear timer", n_rf - n0, 1);
    chkw("R3 delay unchanged by bounce", t_rf - t1, s_cyc(0) - CPT + 1, s_cyc(0) + 2);
    waitc(p_cyc(0) + 4);
    release_settle();

    // R5: release during the pulse, then R6 re-arm
    ps = 2'd1; waitc(3);
    n0 = n_rf;
    press(1, td);
    while (n_rf == n0) waitc(1);
    waitc(3);
    ba = 1'b1; bb = 1'b1;
    waitc(p_cyc(1) + 4);
    chk(t_rr - t_rf == p_cyc(1), "R5 pulse not shortened", t_rr - t_rf, p_cyc(1));
    chk(n_rf == n0 + 1, "R5 no restart after release", n_rf - n0, 1);
    waitc(DB * CPT + 20);
    press(2, td);
    waitc(DB * CPT + 6 + s_cyc(0) + 4);
    chk(n_rf == n0 + 2, "R6 re-armed after long release", n_rf - n0, 2);
    waitc(p_cyc(1) + 4);
    ba = 1'b1; bb = 1'b1; waitc(5); ba = 1'b0; bb = 1'b0;
    waitc(s_cyc(0) + DB * CPT + 20);
    chk(n_rf == n0 + 2, "R6 short release does not re-arm", n_rf - n0, 2);
    chk(and_n == 1'b0, "R7 short release keeps and low", int'(and_n), 0);
    ba = 1'b1; bb = 1'b1;
    waitc(DB * CPT + 20);
    press(0, td);
    waitc(DB * CPT + 6 + s_cyc(0) + 4);
    chk(n_rf == n0 + 3, "R6 re-armed after debounced release", n_rf - n0, 3);
    waitc(p_cyc(1) + 4);
    release_settle();

    // R2: select change during a press has no effect on that press
    ss = 2'd0; ps = 2'd0; waitc(3);
    n0 = n_rf;
    press(2, td);
    waitc(DB * CPT + 6);
    t1 = t_af;
    waitc(20);
    ss = 2'd3; ps = 2'd2;
    waitc(s_cyc(0) + p_cyc(0) + 4);
    chk(n_rf == n0 + 1, "R2 pulse with latched selects", n_rf - n0, 1);
    chkw("R2 setup uses latched select", t_rf - t1, s_cyc(0) - CPT + 1, s_cyc(0) + 2);
    chk(t_rr - t_rf == p_cyc(0), "R2 width uses latched select", t_rr - t_rf, p_cyc(0));
    release_settle();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule